// File: doc/BRIEF.md
# Test-and-Set Lock Bank

This block holds a small set of single-bit locks that several command ports of a shared memory controller use to build mutual exclusion. Each port presents one command at a time: either an acquire or a release, each naming one lock. An acquire aimed at a free lock takes the lock for that port in one indivisible step. An acquire aimed at a held lock is not acknowledged. The port keeps the command on its inputs, so nothing behind it in that port's stream can move until the acquire is granted.

Each lock remembers which port owns it. Only the owner can free it. When several ports ask for the same free lock in one cycle, the one that was granted a lock least recently wins. That recency order is shared by all locks, and only grants count toward it. The handshake is valid/acknowledge. The acknowledge is combinational from registered lock state, so a command completes in the cycle it is acknowledged. The port may present its next command in the following cycle.

Top module: `mutex_bank`

## Requirements
- R1: After reset every lock is free and unowned, so an acquire from any port to any lock is acknowledged in the first cycle it is presented.
- R2: An acquire (`req_release`=0) to a free lock is acknowledged in the cycle it is presented, and from the next cycle the lock is held by that port. Lock index for port p is `req_lock[2p+1:2p]`.
- R3: An acquire to a held lock is not acknowledged and stays pending for as long as the lock is held.
- R4: A release (`req_release`=1) from the owner is acknowledged at once and frees the lock at the next edge. An acquire waiting on that lock is not acknowledged in the release cycle, but can be in the next one.
- R5: A release from a port that does not own the lock, or a release of a free lock, is acknowledged but changes no lock state.
- R6: When several ports request the same free lock in one cycle, exactly one of them is acknowledged.
- R7: Among contenders for a lock, the winner is the port granted least recently. At reset, a lower port index counts as less recently granted. Releases do not change the order.
- R8: Requests for different free locks in the same cycle are all granted together.
- R9: An acquire from the owner for a lock it already holds is not acknowledged (no re-entry).
- R10: No acknowledge is raised on a port whose `req_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 4 | Per-port command present |
| req_release | input | 4 | Per-port operation: 0 acquire, 1 release |
| req_lock | input | 8 | Per-port lock index, 2 bits per port, port 0 in the low bits |
| req_ack | output | 4 | Per-port command completed this cycle |

## Verification
A release and an acquire can land on the same lock in the same cycle. The stimulus provokes this with an owner release and a waiting acquire presented together. It is judged correct when only the release is acknowledged and the acquire succeeds one cycle later. Contention for one lock can also coincide with grants on other locks. That case is provoked by a cycle in which two ports fight over one lock while a third takes a different lock. It is judged by the exact acknowledge pattern, and by a later tie whose outcome depends on the recency order that the mixed cycle produced.

// File: rtl/mutex_pkg.sv
package mutex_pkg;

    typedef enum logic {
        OP_ACQUIRE = 1'b0,
        OP_RELEASE = 1'b1
    } mtx_op_e;

    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/mutex_lrs_arb.sv
module mutex_lrs_arb
    import mutex_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int NUM_LOCKS = 4
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic [NUM_LOCKS-1:0][NUM_PORTS-1:0]  want,
    output logic [NUM_LOCKS-1:0][NUM_PORTS-1:0]  grant
);

    // older[i][j] = 1 when port i was granted less recently than port j
    logic [NUM_PORTS-1:0][NUM_PORTS-1:0] older;
    logic [NUM_PORTS-1:0]                served;

    always_comb begin
        for (int l = 0; l < NUM_LOCKS; l++) begin
            for (int i = 0; i < NUM_PORTS; i++) begin
                grant[l][i] = want[l][i];
                for (int j = 0; j < NUM_PORTS; j++) begin
                    if (j != i && want[l][j] && !older[i][j])
                        grant[l][i] = 1'b0;
                end
            end
        end
    end

    always_comb begin
        served = '0;
        for (int l = 0; l < NUM_LOCKS; l++)
            served = served | grant[l];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_PORTS; i++)
                for (int j = 0; j < NUM_PORTS; j++)
                    older[i][j] <= (i < j);
        end else begin
            for (int i = 0; i < NUM_PORTS; i++)
                for (int j = 0; j < NUM_PORTS; j++)
                    if (i != j) begin
                        if (served[i] && !served[j])
                            older[i][j] <= 1'b0;
                        else if (served[j] && !served[i])
                            older[i][j] <= 1'b1;
                    end
        end
    end

endmodule

// File: rtl/mutex_lock_cell.sv
module mutex_lock_cell
    import mutex_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    localparam int PORT_W = idx_w(NUM_PORTS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_PORTS-1:0]  take,
    input  logic [NUM_PORTS-1:0]  drop,
    output logic                  held,
    output logic [PORT_W-1:0]     owner
);

    logic [PORT_W-1:0] take_idx;
    logic              owner_drop;

    always_comb begin
        take_idx = '0;
        for (int p = 0; p < NUM_PORTS; p++)
            if (take[p]) take_idx = PORT_W'(p);
    end

    assign owner_drop = held && drop[owner];

    always_ff @(posedge clk) begin
        if (rst) begin
            held  <= 1'b0;
            owner <= '0;
        end else if (|take) begin
            held  <= 1'b1;
            owner <= take_idx;
        end else if (owner_drop) begin
            held  <= 1'b0;
            owner <= '0;
        end
    end

endmodule

// File: rtl/mutex_bank.sv
module mutex_bank
    import mutex_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int NUM_LOCKS = 4,
    localparam int LOCK_W = idx_w(NUM_LOCKS),
    localparam int PORT_W = idx_w(NUM_PORTS)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_PORTS-1:0]          req_valid,
    input  logic [NUM_PORTS-1:0]          req_release,
    input  logic [NUM_PORTS*LOCK_W-1:0]   req_lock,
    output logic [NUM_PORTS-1:0]          req_ack
);

    logic [NUM_LOCKS-1:0][NUM_PORTS-1:0] lock_want;
    logic [NUM_LOCKS-1:0][NUM_PORTS-1:0] lock_grant;
    logic [NUM_LOCKS-1:0][NUM_PORTS-1:0] lock_drop;
    logic [NUM_LOCKS-1:0]                lock_held;
    logic [NUM_LOCKS-1:0][PORT_W-1:0]    lock_owner;
    logic [NUM_PORTS-1:0]                port_granted;

    always_comb begin
        for (int l = 0; l < NUM_LOCKS; l++) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                logic hit;
                hit = req_valid[p] &&
                      (req_lock[p*LOCK_W +: LOCK_W] == LOCK_W'(l));
                lock_want[l][p] = hit && (mtx_op_e'(req_release[p]) == OP_ACQUIRE)
                                  && !lock_held[l];
                lock_drop[l][p] = hit && (mtx_op_e'(req_release[p]) == OP_RELEASE);
            end
        end
    end

    mutex_lrs_arb #(
        .NUM_PORTS(NUM_PORTS),
        .NUM_LOCKS(NUM_LOCKS)
    ) u_arb (
        .clk   (clk),
        .rst   (rst),
        .want  (lock_want),
        .grant (lock_grant)
    );

    for (genvar l = 0; l < NUM_LOCKS; l++) begin : g_lock
        mutex_lock_cell #(
            .NUM_PORTS(NUM_PORTS)
        ) u_cell (
            .clk   (clk),
            .rst   (rst),
            .take  (lock_grant[l]),
            .drop  (lock_drop[l]),
            .held  (lock_held[l]),
            .owner (lock_owner[l])
        );
    end

    always_comb begin
        port_granted = '0;
        for (int l = 0; l < NUM_LOCKS; l++)
            port_granted = port_granted | lock_grant[l];
    end

    assign req_ack = req_valid & (req_release | port_granted);

endmodule

// File: rtl/mutex_bank_chk.sv
module mutex_bank_chk
    import mutex_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int NUM_LOCKS = 4,
    localparam int LOCK_W = idx_w(NUM_LOCKS),
    localparam int PORT_W = idx_w(NUM_PORTS)
) (
    input logic                                 clk,
    input logic                                 rst,
    input logic [NUM_PORTS-1:0]                 req_valid,
    input logic [NUM_PORTS-1:0]                 req_release,
    input logic [NUM_PORTS*LOCK_W-1:0]          req_lock,
    input logic [NUM_PORTS-1:0]                 req_ack,
    input logic [NUM_LOCKS-1:0][NUM_PORTS-1:0]  lock_grant,
    input logic [NUM_LOCKS-1:0]                 lock_held,
    input logic [NUM_LOCKS-1:0][PORT_W-1:0]     lock_owner
);

    for (genvar l = 0; l < NUM_LOCKS; l++) begin : g_l
        logic owner_rel;
        assign owner_rel = req_valid[lock_owner[l]] && req_release[lock_owner[l]] &&
                           (req_lock[lock_owner[l]*LOCK_W +: LOCK_W] == LOCK_W'(l));

        p_single_grant_r6: assert property (@(posedge clk) disable iff (rst)
            $onehot0(lock_grant[l]));

        p_take_sets_r2: assert property (@(posedge clk) disable iff (rst)
            (|lock_grant[l]) |=> lock_held[l]);

        p_held_blocks_r3: assert property (@(posedge clk) disable iff (rst)
            lock_held[l] |-> (lock_grant[l] == '0));

        p_no_steal_r5: assert property (@(posedge clk) disable iff (rst)
            (lock_held[l] && !owner_rel) |=> (lock_held[l] && $stable(lock_owner[l])));
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_p
        p_release_ack_r4: assert property (@(posedge clk) disable iff (rst)
            (req_valid[p] && req_release[p]) |-> req_ack[p]);

        p_ack_needs_valid_r10: assert property (@(posedge clk) disable iff (rst)
            req_ack[p] |-> req_valid[p]);
    end

endmodule

bind mutex_bank mutex_bank_chk #(
    .NUM_PORTS(NUM_PORTS),
    .NUM_LOCKS(NUM_LOCKS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_release (req_release),
    .req_lock    (req_lock),
    .req_ack     (req_ack),
    .lock_grant  (lock_grant),
    .lock_held   (lock_held),
    .lock_owner  (lock_owner)
);

// File: tb/mutex_bank_test.sv
module mutex_bank_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] req_valid = '0;
    logic [3:0] req_release = '0;
    logic [7:0] req_lock = '0;
    logic [3:0] req_ack;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    mutex_bank uut (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_release (req_release),
        .req_lock    (req_lock),
        .req_ack     (req_ack)
    );

    // {valid, release, lock indices {p3,p2,p1,p0}, expected ack}
    localparam int NV = 18;
    localparam logic [19:0] VEC [NV] = '{
        {4'b0000, 4'b0000, 8'b00000000, 4'b0000},  // R10 idle
        {4'b0001, 4'b0000, 8'b00000000, 4'b0001},  // R1 R2 p0 takes L0
        {4'b0010, 4'b0000, 8'b00000000, 4'b0000},  // R3 p1 blocked on L0
        {4'b0110, 4'b0100, 8'b00000000, 4'b0100},  // R5 p2 non-owner release
        {4'b0010, 4'b0000, 8'b00000000, 4'b0000},  // R5 L0 still held
        {4'b0011, 4'b0000, 8'b00000000, 4'b0000},  // R9 owner re-acquire blocks
        {4'b0011, 4'b0001, 8'b00000000, 4'b0001},  // R4 release, waiter not same cycle
        {4'b0010, 4'b0000, 8'b00000000, 4'b0010},  // R4 waiter granted next cycle
        {4'b1101, 4'b0000, 8'b01010010, 4'b0101},  // R6 R8 p2 beats p3 on L1, p0 takes L2
        {4'b1000, 4'b0000, 8'b01000000, 4'b0000},  // R3 p3 waits on L1
        {4'b1100, 4'b0100, 8'b01010000, 4'b0100},  // R4 p2 releases L1
        {4'b1000, 4'b0000, 8'b01000000, 4'b1000},  // R4 p3 takes L1
        {4'b0101, 4'b0000, 8'b00110011, 4'b0100},  // R7 p2 older than p0 on L3
        {4'b0010, 4'b0010, 8'b00000000, 4'b0010},  // R4 p1 frees L0
        {4'b0011, 4'b0000, 8'b00000000, 4'b0010},  // R7 p1 older than p0
        {4'b0100, 4'b0100, 8'b00110000, 4'b0100},  // R4 p2 frees L3
        {4'b0100, 4'b0100, 8'b00110000, 4'b0100},  // R5 release of free lock
        {4'b0001, 4'b0000, 8'b00000011, 4'b0001}   // R5 L3 free for p0
    };

    task automatic check(input logic [3:0] exp, input string tag);
        n_checks++;
        if (req_ack !== exp) begin
            n_fail++;
            $display("FAIL %s: ack=%b expected=%b", tag, req_ack, exp);
        end
    endtask

    task automatic apply(input logic [3:0] v, input logic [3:0] r, input logic [7:0] lk,
                         input logic [3:0] exp, input string tag);
        @(negedge clk);
        req_valid = v;
        req_release = r;
        req_lock = lk;
        #3;
        check(exp, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        req_valid = '0;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin : watchdog
        #200000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: ack=%b expected=done", req_ack);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        #3;
        check(4'b0000, "R1 reset idle");
        for (int k = 0; k < NV; k++) begin
            apply(VEC[k][19:16], VEC[k][15:12], VEC[k][11:4], VEC[k][3:0],
                  $sformatf("vector %0d", k));
        end
        // R1 R8: reset frees everything, all four locks taken together
        do_reset();
        apply(4'b1111, 4'b0000, 8'b11100100, 4'b1111, "R1 R8 all locks after reset");
        // R7: reset order favours lower index
        do_reset();
        apply(4'b0110, 4'b0000, 8'b00101000, 4'b0010, "R7 reset order p1 over p2");
        apply(4'b0100, 4'b0000, 8'b00100000, 4'b0000, "R3 p2 waits after loss");
        @(negedge clk);
        req_valid = '0;
        #3;
        check(4'b0000, "R10 no valid no ack");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule